// File: doc/BRIEF.md
# Rolling Shutter Row Sequencer

This block schedules the rows of an image window under a rolling electronic shutter. Each pulse on the row tick input is one row slot. In a slot the block may name one row to be reset, which starts that row's integration, and a different row to be read out. The row read out is the one whose integration time has just run out. Column timing, analog sampling and pixel transfer are handled elsewhere. This block only says which row gets which operation in which slot.

A run starts on the first tick after the run request rises. The window and the integration time are sampled in that slot and stay fixed until the run ends. In single-frame mode the block reads one frame and then idles. In continuous mode it repeats frames with a period of max(frame rows, integration rows) slots. So a long integration time adds idle slots between frames. Clearing the run request ends a run in one of two ways. A graceful stop reads out every frame whose resets have already begun. An abort drops the run at once and pulses the completion outputs.

Top module: `row_shutter_seq`

## Requirements
- R1: After reset every output is 0. On the first tick after `run_req` rises while idle, the cycle after that tick shows `run_flag`=1 together with a reset strobe for the first window row. All strobes and pulses are registered and appear one clock after the tick that causes them.
- R2: Let slot s count from 0 at the start of a run and let P be the frame period. In every slot where s mod P < F (F = number of window rows), `rst_strobe` pulses with `rst_row` = first + (s mod P). No reset strobe occurs while `run_flag` is 0.
- R3: With integration K, a row is read exactly K slots after its reset. So in slot s ≥ K with t = s−K and t mod P < F, `rd_strobe` pulses with `rd_row` = first + (t mod P). No read occurs before slot K.
- R4: `row_done` pulses with every read strobe. `frame_done` also pulses when the row read is the bottom row of the window.
- R5: In continuous mode the reset pointer wraps to the top row every P = max(F, K) slots. Frames follow each other with no idle slot when K ≤ F, and with K−F idle slots when K > F.
- R6: In single-frame mode, `capture_done` pulses together with the bottom-row `frame_done`, and `run_flag` drops in that same cycle. No new run starts while `run_req` stays high. A new rising edge is needed.
- R7: If `run_req` is cleared while `stop_at_end`=1, no new frame begins resetting. Every frame whose resets have begun is read out in full. `capture_done` pulses with the last `frame_done`, and the block then stays quiet.
- R8: If `run_req` is cleared while `stop_at_end`=0 during a run, then in the next cycle `row_done`, `frame_done` and `capture_done` pulse once and `run_flag` is 0. No further strobes follow.
- R9: The first window row has its two low bits forced to 0. A last row below first+3 is raised to first+3, so a window is never shorter than 4 rows.
- R10: An integration value of 0 is treated as 1. Window, integration and mode inputs that change during a run have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_tick | input | 1 | One-cycle pulse per row slot |
| run_req | input | 1 | Run request; a rising edge starts a run |
| cont_mode | input | 1 | 1 = continuous frames, 0 = single frame |
| stop_at_end | input | 1 | 1 = graceful stop when run_req clears, 0 = abort |
| win_first | input | ROW_W | Top row of the window |
| win_last | input | ROW_W | Bottom row of the window |
| integ_rows | input | INT_W | Integration time in row slots |
| rst_strobe | output | 1 | Reset-row strobe |
| rst_row | output | ROW_W | Row being reset |
| rd_strobe | output | 1 | Read-row strobe |
| rd_row | output | ROW_W | Row being read |
| row_done | output | 1 | Row-complete pulse |
| frame_done | output | 1 | Frame-complete pulse |
| capture_done | output | 1 | Capture-complete pulse at the end of a run |
| run_flag | output | 1 | High while a run is in progress |

## Verification
The bench sweeps integration times from 1 to 9 over windows of 4 and 7 rows. This covers the crossing from K < F (reads overlap the next frame's resets) to K > F (idle gap). A design that got the period wrong would wrap the reset pointer too early and read rows that were never reset. A design off by one in the integration delay would read every row one slot early or late.

Graceful stops are placed just before and just after a frame-wrap decision. A sequencer that counted outstanding frames wrongly would either drop a frame it had already reset or read one frame too many. Unaligned and too-short windows, a zero integration value and inputs churned mid-run expose a block that fails to clamp or fails to hold its settings. Aborts and a run request held high after a single frame check that completion fires once and that no spurious restart follows.

// File: rtl/rsq_pkg.sv
// Shared definitions for the rolling shutter row sequencer.
// Assumes nothing beyond the parameters of the modules that import it.
package rsq_pkg;
    // Low bits of the first window row that are forced to zero
    localparam int RSQ_ALIGN_BITS = 2;
    // Minimum distance from the first to the last window row
    localparam int RSQ_MIN_SPAN = 3;

    typedef enum logic [1:0] {
        RSQ_IDLE  = 2'd0,
        RSQ_RUN   = 2'd1,
        RSQ_DRAIN = 2'd2
    } rsq_state_e;
endpackage

// File: rtl/rsq_ctrl.sv
// Run control for the row sequencer.
// - Detects the run request edge and starts a run on a tick.
// - Samples and clamps the window and integration settings at start.
// - Tracks how many frames have begun resetting but are not yet read out.
// - Decides graceful drain, abort or natural end.
// Assumes row_tick is a single-cycle strobe and that the settings
// are only sampled in the start slot.
module rsq_ctrl
    import rsq_pkg::*;
#(
    parameter int ROW_W = 10,
    parameter int INT_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             cont_in,
    input  logic             stop_at_end,
    input  logic [ROW_W-1:0] first_in,
    input  logic [ROW_W-1:0] last_in,
    input  logic [INT_W-1:0] integ_in,
    input  logic             rs_wrap,
    input  logic             rd_bottom,
    output logic             start,
    output logic             abort,
    output logic             slot,
    output logic [ROW_W-1:0] cfg_first,
    output logic [CNT_W-1:0] cfg_len,
    output logic [CNT_W-1:0] cfg_period,
    output logic [INT_W-1:0] cfg_integ,
    output logic             cont_ok,
    output logic             rd_more,
    output logic             run_flag,
    output logic             capture_q,
    output logic             abort_q
);
    localparam logic [ROW_W-1:0] ALIGN_MASK = ROW_W'((1 << RSQ_ALIGN_BITS) - 1);

    rsq_state_e       state_q;
    logic             run_d_q;
    logic             pend_q;
    logic [ROW_W-1:0] first_q;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] per_q;
    logic [INT_W-1:0] integ_q;
    logic             cont_q;
    logic [1:0]       out_q;

    logic [ROW_W-1:0] first_al;
    logic [ROW_W:0]   span_min;
    logic [ROW_W:0]   last_eff;
    logic [CNT_W-1:0] len_new;
    logic [INT_W-1:0] integ_new;
    logic [CNT_W-1:0] per_new;
    logic             idle;
    logic             finish;

    // Clamp the requested window and integration into a legal setting
    always_comb begin
        first_al  = first_in & ~ALIGN_MASK;
        span_min  = {1'b0, first_al} + (ROW_W+1)'(RSQ_MIN_SPAN);
        last_eff  = ({1'b0, last_in} < span_min) ? span_min : {1'b0, last_in};
        len_new   = CNT_W'(last_eff) - CNT_W'(first_al) + CNT_W'(1);
        integ_new = (integ_in == '0) ? INT_W'(1) : integ_in;
        per_new   = (CNT_W'(integ_new) > len_new) ? CNT_W'(integ_new) : len_new;
    end

    // Slot qualification, start/abort detection and frame bookkeeping terms
    always_comb begin
        idle       = (state_q == RSQ_IDLE);
        start      = tick & idle & pend_q & run;
        abort      = (state_q == RSQ_RUN) & ~run & ~stop_at_end;
        slot       = tick & ~idle & ~abort;
        cfg_first  = start ? first_al  : first_q;
        cfg_len    = start ? len_new   : len_q;
        cfg_period = start ? per_new   : per_q;
        cfg_integ  = start ? integ_new : integ_q;
        cont_ok    = cont_q & (state_q == RSQ_RUN) & run;
        rd_more    = ({1'b0, out_q} + {2'b00, rs_wrap}) > 3'd1;
        finish     = slot & rd_bottom & ~rd_more;
        run_flag   = ~idle;
    end

    // Run state, sampled settings, outstanding-frame count and end pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RSQ_IDLE;
            run_d_q   <= 1'b0;
            pend_q    <= 1'b0;
            first_q   <= '0;
            len_q     <= '0;
            per_q     <= '0;
            integ_q   <= '0;
            cont_q    <= 1'b0;
            out_q     <= '0;
            capture_q <= 1'b0;
            abort_q   <= 1'b0;
        end else begin
            run_d_q   <= run;
            capture_q <= 1'b0;
            abort_q   <= 1'b0;
            if (!run || start) begin
                pend_q <= 1'b0;
            end else if (!run_d_q) begin
                pend_q <= 1'b1;
            end
            if (start) begin
                state_q <= RSQ_RUN;
                first_q <= first_al;
                len_q   <= len_new;
                per_q   <= per_new;
                integ_q <= integ_new;
                cont_q  <= cont_in;
                out_q   <= 2'd1;
            end else if (abort) begin
                state_q   <= RSQ_IDLE;
                out_q     <= '0;
                capture_q <= 1'b1;
                abort_q   <= 1'b1;
            end else begin
                if (state_q == RSQ_RUN && !run) begin
                    state_q <= RSQ_DRAIN;
                end
                if (slot) begin
                    out_q <= out_q + {1'b0, rs_wrap} - {1'b0, rd_bottom};
                end
                if (finish) begin
                    state_q   <= RSQ_IDLE;
                    capture_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rsq_reset_walker.sv
// Reset pointer of the row sequencer.
// Walks a phase counter through one frame period per frame. It issues a
// reset strobe in the first len phases and wraps or stops at the period
// end. Assumes period >= len >= 4 and that start and slot never coincide.
module rsq_reset_walker #(
    parameter int ROW_W = 10,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             slot,
    input  logic             abort,
    input  logic [ROW_W-1:0] first,
    input  logic [CNT_W-1:0] len,
    input  logic [CNT_W-1:0] period,
    input  logic             cont_ok,
    output logic             wrap,
    output logic             strb,
    output logic [ROW_W-1:0] row
);
    logic             on_q;
    logic [CNT_W-1:0] ph_q;
    logic             at_end;

    // Period end detection and the frame-wrap decision
    always_comb begin
        at_end = (ph_q == period - CNT_W'(1));
        wrap   = slot & on_q & at_end & cont_ok;
    end

    // Phase counter and registered reset strobe/address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q <= 1'b0;
            ph_q <= '0;
            strb <= 1'b0;
            row  <= '0;
        end else begin
            strb <= 1'b0;
            if (abort) begin
                on_q <= 1'b0;
            end else if (start) begin
                on_q <= 1'b1;
                ph_q <= CNT_W'(1);
                strb <= 1'b1;
                row  <= first;
            end else if (slot && on_q) begin
                if (ph_q < len) begin
                    strb <= 1'b1;
                    row  <= first + ROW_W'(ph_q);
                end
                if (at_end) begin
                    if (cont_ok) begin
                        ph_q <= '0;
                    end else begin
                        on_q <= 1'b0;
                    end
                end else begin
                    ph_q <= ph_q + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/rsq_read_walker.sv
// Read pointer of the row sequencer.
// Waits integ-1 slots after the start slot, then follows the same phase
// pattern as the reset pointer, so each row is read integ slots after its
// reset. Stops after a bottom-row read when no further frame is pending.
// Assumes integ >= 1 and period >= len >= 4.
module rsq_read_walker #(
    parameter int ROW_W = 10,
    parameter int INT_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             slot,
    input  logic             abort,
    input  logic [ROW_W-1:0] first,
    input  logic [CNT_W-1:0] len,
    input  logic [CNT_W-1:0] period,
    input  logic [INT_W-1:0] integ,
    input  logic             more,
    output logic             bottom,
    output logic             strb,
    output logic [ROW_W-1:0] row,
    output logic             frame_q
);
    logic             on_q;
    logic [INT_W-1:0] wait_q;
    logic [CNT_W-1:0] ph_q;
    logic             reading;

    // A slot reads once the integration wait has run out
    always_comb begin
        reading = slot & on_q & (wait_q == '0);
        bottom  = reading & (ph_q == len - CNT_W'(1));
    end

    // Integration wait, read phase and registered read strobe/address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q    <= 1'b0;
            wait_q  <= '0;
            ph_q    <= '0;
            strb    <= 1'b0;
            row     <= '0;
            frame_q <= 1'b0;
        end else begin
            strb    <= 1'b0;
            frame_q <= 1'b0;
            if (abort) begin
                on_q <= 1'b0;
            end else if (start) begin
                on_q   <= 1'b1;
                wait_q <= integ - INT_W'(1);
                ph_q   <= '0;
            end else if (slot && on_q) begin
                if (wait_q != '0) begin
                    wait_q <= wait_q - INT_W'(1);
                end else begin
                    if (ph_q < len) begin
                        strb <= 1'b1;
                        row  <= first + ROW_W'(ph_q);
                    end
                    if (bottom) begin
                        frame_q <= 1'b1;
                        if (!more) begin
                            on_q <= 1'b0;
                        end
                    end
                    if (ph_q == period - CNT_W'(1)) begin
                        ph_q <= '0;
                    end else begin
                        ph_q <= ph_q + CNT_W'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/row_shutter_seq.sv
// Rolling shutter row sequencer, top level.
// One row slot per row_tick: resets one window row and reads the row whose
// integration has just expired. Supports single and continuous frames and
// graceful or immediate stop. All outputs are registered.
// Assumes row_tick is a one-cycle pulse from an external row timer.
module row_shutter_seq #(
    parameter int ROW_W = 10,
    parameter int INT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_tick,
    input  logic             run_req,
    input  logic             cont_mode,
    input  logic             stop_at_end,
    input  logic [ROW_W-1:0] win_first,
    input  logic [ROW_W-1:0] win_last,
    input  logic [INT_W-1:0] integ_rows,
    output logic             rst_strobe,
    output logic [ROW_W-1:0] rst_row,
    output logic             rd_strobe,
    output logic [ROW_W-1:0] rd_row,
    output logic             row_done,
    output logic             frame_done,
    output logic             capture_done,
    output logic             run_flag
);
    localparam int CNT_W = ((ROW_W + 1) > INT_W) ? (ROW_W + 1) : INT_W;

    logic             start;
    logic             abort;
    logic             slot;
    logic [ROW_W-1:0] cfg_first;
    logic [CNT_W-1:0] cfg_len;
    logic [CNT_W-1:0] cfg_period;
    logic [INT_W-1:0] cfg_integ;
    logic             cont_ok;
    logic             rd_more;
    logic             rs_wrap;
    logic             rd_bottom;
    logic             rd_frame;
    logic             abort_q;

    rsq_ctrl #(
        .ROW_W(ROW_W), .INT_W(INT_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (row_tick),
        .run        (run_req),
        .cont_in    (cont_mode),
        .stop_at_end(stop_at_end),
        .first_in   (win_first),
        .last_in    (win_last),
        .integ_in   (integ_rows),
        .rs_wrap    (rs_wrap),
        .rd_bottom  (rd_bottom),
        .start      (start),
        .abort      (abort),
        .slot       (slot),
        .cfg_first  (cfg_first),
        .cfg_len    (cfg_len),
        .cfg_period (cfg_period),
        .cfg_integ  (cfg_integ),
        .cont_ok    (cont_ok),
        .rd_more    (rd_more),
        .run_flag   (run_flag),
        .capture_q  (capture_done),
        .abort_q    (abort_q)
    );

    rsq_reset_walker #(
        .ROW_W(ROW_W), .CNT_W(CNT_W)
    ) u_rst (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .slot   (slot),
        .abort  (abort),
        .first  (cfg_first),
        .len    (cfg_len),
        .period (cfg_period),
        .cont_ok(cont_ok),
        .wrap   (rs_wrap),
        .strb   (rst_strobe),
        .row    (rst_row)
    );

    rsq_read_walker #(
        .ROW_W(ROW_W), .INT_W(INT_W), .CNT_W(CNT_W)
    ) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .slot   (slot),
        .abort  (abort),
        .first  (cfg_first),
        .len    (cfg_len),
        .period (cfg_period),
        .integ  (cfg_integ),
        .more   (rd_more),
        .bottom (rd_bottom),
        .strb   (rd_strobe),
        .row    (rd_row),
        .frame_q(rd_frame)
    );

    // An abort reports row, frame and capture completion together
    always_comb begin
        row_done   = rd_strobe | abort_q;
        frame_done = rd_frame | abort_q;
    end
endmodule

// File: rtl/row_shutter_seq_chk.sv
// Temporal checks on the row sequencer outputs, bound to every instance.
module row_shutter_seq_chk #(
    parameter int ROW_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_strobe,
    input logic [ROW_W-1:0] rst_row,
    input logic             rd_strobe,
    input logic             row_done,
    input logic             frame_done,
    input logic             capture_done,
    input logic             run_flag
);
    // R1
    first_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_flag) |-> rst_strobe && ((rst_row & ROW_W'(3)) == '0));

    // R2
    no_idle_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_flag |-> !rst_strobe);

    // R3
    late_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && !run_flag |-> frame_done && capture_done);

    // R4
    frame_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> row_done);

    // R6
    cap_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_done |-> frame_done && !run_flag);

    // R8
    abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_done && !rd_strobe |-> frame_done && capture_done && !run_flag);

    // R8
    quiet_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_done |=> !rd_strobe);
endmodule

bind row_shutter_seq row_shutter_seq_chk #(.ROW_W(ROW_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_strobe  (rst_strobe),
    .rst_row     (rst_row),
    .rd_strobe   (rd_strobe),
    .row_done    (row_done),
    .frame_done  (frame_done),
    .capture_done(capture_done),
    .run_flag    (run_flag)
);

// File: tb/sim_row_shutter_seq.sv
module sim_row_shutter_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        row_tick = 1'b0;
    logic        run_req = 1'b0;
    logic        cont_mode = 1'b0;
    logic        stop_at_end = 1'b1;
    logic [9:0]  win_first = '0;
    logic [9:0]  win_last = '0;
    logic [15:0] integ_rows = '0;
    logic        rst_strobe, rd_strobe, row_done, frame_done, capture_done, run_flag;
    logic [9:0]  rst_row, rd_row;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    row_shutter_seq u0 (
        .clk(clk), .rst_n(rst_n), .row_tick(row_tick), .run_req(run_req),
        .cont_mode(cont_mode), .stop_at_end(stop_at_end),
        .win_first(win_first), .win_last(win_last), .integ_rows(integ_rows),
        .rst_strobe(rst_strobe), .rst_row(rst_row), .rd_strobe(rd_strobe),
        .rd_row(rd_row), .row_done(row_done), .frame_done(frame_done),
        .capture_done(capture_done), .run_flag(run_flag)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One tick; returns at the negedge after the edge that registers its result
    task automatic pulse_tick();
        @(negedge clk) row_tick = 1'b1;
        @(negedge clk) row_tick = 1'b0;
    endtask

    task automatic quiet_ticks(string tag, int n);
        for (int i = 0; i < n; i++) begin
            pulse_tick();
            chk({tag, " rst_strobe quiet"}, int'(rst_strobe), 0);
            chk({tag, " rd_strobe quiet"}, int'(rd_strobe), 0);
            chk({tag, " run_flag quiet"}, int'(run_flag), 0);
        end
    endtask

    // Run one scenario and compare every slot against the arithmetic schedule
    task automatic run_case(int f, int l, int k, bit cont, int stop_after, bit churn, string ctag);
        int fa, le, nf, ke, per, nfr, last;
        fa   = f & ~3;
        le   = (l < fa + 3) ? fa + 3 : l;
        nf   = le - fa + 1;
        ke   = (k == 0) ? 1 : k;
        per  = (ke > nf) ? ke : nf;
        nfr  = cont ? ((stop_after + 1) / per + 1) : 1;
        last = (nfr - 1) * per + nf - 1 + ke;
        @(negedge clk);
        win_first = 10'(f); win_last = 10'(l); integ_rows = 16'(k);
        cont_mode = cont; stop_at_end = 1'b1; run_req = 1'b1;
        @(negedge clk); @(negedge clk);
        for (int s = 0; s <= last; s++) begin
            bit ers, erd, efd;
            int t;
            if (cont && s == stop_after + 1) begin
                @(negedge clk) run_req = 1'b0;
            end
            pulse_tick();
            ers = (s / per < nfr) && (s % per < nf);
            t   = s - ke;
            erd = (s >= ke) && (t / per < nfr) && (t % per < nf);
            efd = erd && (t % per == nf - 1);
            chk({(s == 0) ? "R1" : "R2", "/", ctag, " rst_strobe"}, int'(rst_strobe), int'(ers));
            if (ers) chk({"R2/", ctag, " rst_row"}, int'(rst_row), fa + s % per);
            chk({"R3/", ctag, " rd_strobe"}, int'(rd_strobe), int'(erd));
            if (erd) chk({"R3/", ctag, " rd_row"}, int'(rd_row), fa + t % per);
            chk({"R4/", ctag, " row_done"}, int'(row_done), int'(erd));
            chk({"R4/", ctag, " frame_done"}, int'(frame_done), int'(efd));
            chk({cont ? "R7" : "R6", "/", ctag, " capture_done"}, int'(capture_done), int'(s == last));
            chk({"R1/", ctag, " run_flag"}, int'(run_flag), int'(s < last));
            if (churn && s == 0) begin
                win_first = 10'(f + 40); win_last = 10'(l + 60);
                integ_rows = 16'(ke + 3); cont_mode = ~cont;
            end
        end
        // Run request may still be high: no restart without a new edge
        quiet_ticks({cont ? "R7/" : "R6/", ctag}, 3);
        @(negedge clk) run_req = 1'b0;
        cont_mode = cont;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset rst_strobe", int'(rst_strobe), 0);
        chk("R1 reset rd_strobe", int'(rd_strobe), 0);
        chk("R1 reset frame_done", int'(frame_done), 0);
        chk("R1 reset capture_done", int'(capture_done), 0);
        chk("R1 reset run_flag", int'(run_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // No run request yet: ticks do nothing
        quiet_ticks("R1 idle", 2);

        // Single-frame sweep over integration time and two window sizes
        for (int k = 1; k <= 9; k++) begin
            run_case(0, 3, k, 1'b0, 0, 1'b0, "R6");
            run_case(8, 14, k, 1'b0, 0, 1'b0, "R6");
        end
        // Window clamps and integration floor
        run_case(5, 5, 2, 1'b0, 0, 1'b0, "R9");
        run_case(13, 30, 5, 1'b0, 0, 1'b0, "R9");
        run_case(16, 19, 0, 1'b0, 0, 1'b0, "R10");
        run_case(4, 9, 3, 1'b0, 0, 1'b1, "R10");
        // Continuous frames, short and long integration, graceful stops
        run_case(0, 3, 2, 1'b1, 5, 1'b0, "R5");
        run_case(0, 3, 4, 1'b1, 6, 1'b0, "R5");
        run_case(0, 3, 9, 1'b1, 10, 1'b0, "R5");
        run_case(20, 25, 3, 1'b1, 4, 1'b0, "R7");
        run_case(20, 25, 3, 1'b1, 13, 1'b1, "R7");

        // R8: immediate stop
        @(negedge clk);
        win_first = 10'd0; win_last = 10'd3; integ_rows = 16'd3;
        cont_mode = 1'b1; stop_at_end = 1'b1; run_req = 1'b1;
        @(negedge clk); @(negedge clk);
        for (int s = 0; s < 5; s++) pulse_tick();
        chk("R8 run_flag before stop", int'(run_flag), 1);
        stop_at_end = 1'b0; run_req = 1'b0;
        @(negedge clk);
        chk("R8 row_done", int'(row_done), 1);
        chk("R8 frame_done", int'(frame_done), 1);
        chk("R8 capture_done", int'(capture_done), 1);
        chk("R8 run_flag", int'(run_flag), 0);
        chk("R8 rd_strobe", int'(rd_strobe), 0);
        @(negedge clk);
        chk("R8 capture_done once", int'(capture_done), 0);
        chk("R8 frame_done once", int'(frame_done), 0);
        quiet_ticks("R8 after", 3);
        // A fresh edge after an abort starts a clean run
        run_case(0, 3, 1, 1'b0, 0, 1'b0, "R8");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule